// File: doc/BRIEF.md
# Tagged Top-Relative Register Stack

This block holds eight wide floating-point registers and uses them as a stack that grows toward lower register numbers. A three-bit top pointer names the physical register that is the current top. Operations name a register by its distance from the top, so ST(i) is the register `(top + i) mod 8`. Each physical register also carries a two-bit tag. The tag records whether the register holds an ordinary value, a zero, a special value, or nothing at all.

One operation is given per clock through a small opcode. A push steps the top pointer down and stores the value in the new top. A pop marks the top register empty and steps the pointer up. A read presents ST(i). A write replaces ST(i). The block finds stack faults by looking at the tags, not by counting depth. A push that lands on an occupied register is an overflow. A pop or read of an empty register is an underflow. Either fault is raised as an invalid-operation indication for one cycle.

The top pointer and the packed tag word are exported for the status logic. The tag word is indexed by physical register, not by stack position.

Top module: `tagged_reg_stack`

## Requirements
- R1: After reset the top pointer is 0, every tag reads 11 (empty, `tagWord` = 16'hFFFF), and `ovfFlag`, `unfFlag` and `invalidOp` are low.
- R2: A push (opcode 1) sets the top pointer to `(top - 1) mod 8` and stores `wrData` in that register, so that ST(0) then returns it.
- R3: A pop (opcode 2) sets the tag of the current top register to 11 (empty) and sets the top pointer to `(top + 1) mod 8`; the register's data is left in place.
- R4: `rdData` and `rdTag` show, in the same cycle, the contents and tag of physical register `(top + stIdx) mod 8`.
- R5: `tagWord[2k+1:2k]` is the tag of physical register k, for k = 0..7, whatever the top pointer is.
- R6: The tag stored with a value is 01 when exponent bits [78:64] and significand bits [63:0] are all zero; otherwise 10 when bits [78:64] are all ones; otherwise 00. Sign bit 79 has no effect on the tag.
- R7: A write (opcode 4) replaces the value and tag of ST(stIdx) and leaves the top pointer unchanged.
- R8: A push whose target register is not empty sets `ovfFlag` for the one cycle after the push edge, and the push still completes.
- R9: A pop or a read (opcode 3) of an empty ST register sets `unfFlag` for the one cycle after the edge. A pop that underflows still moves the top pointer.
- R10: `invalidOp` is high exactly when `ovfFlag` or `unfFlag` is high.
- R11: Opcode 0 and opcodes 5 to 7 change no register, tag or pointer and raise no fault. A read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opCode | input | 3 | 0 none, 1 push, 2 pop, 3 read, 4 write, 5-7 none |
| stIdx | input | 3 | Distance i of ST(i) from the top |
| wrData | input | 80 | Value for push or write: sign [79], exponent [78:64], significand [63:0] |
| rdData | output | 80 | Contents of ST(stIdx) |
| rdTag | output | 2 | Tag of ST(stIdx) |
| topPtr | output | 3 | Physical number of the top register |
| tagWord | output | 16 | Tags of all physical registers, two bits each |
| ovfFlag | output | 1 | Stack overflow seen on the previous operation |
| unfFlag | output | 1 | Stack underflow seen on the previous operation |
| invalidOp | output | 1 | Invalid-operation indication |

## Verification
A wrong top pointer shows on `topPtr` in the first cycle after the bad edge. It also moves every later ST(i) lookup to the wrong register. A wrong tag shows on `tagWord` one cycle after the push, pop or write that caused it. It then gives a wrong fault flag the next time that register is the target of a push or a read. A value stored in the wrong register stays hidden until that register is selected through `stIdx`. The bench changes `stIdx` every cycle, so such an error appears within a few operations.

// File: rtl/tstk_pkg.sv
package tstk_pkg;

  localparam int STK_DEPTH = 8;
  localparam int STK_PTR_W = $clog2(STK_DEPTH);
  localparam int TAG_W     = 2;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4
  } stackOp_e;

  typedef enum logic [TAG_W-1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 load;    // store wrData and its class tag
    logic                 vacate;  // mark slot empty
    logic [STK_PTR_W-1:0] slot;    // physical register targeted
  } stackStrobe_t;

endpackage

// File: rtl/tstk_ctrl.sv
module tstk_ctrl
  import tstk_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 opCode,
  input  logic [STK_PTR_W-1:0]       stIdx,
  input  logic [TAG_W*STK_DEPTH-1:0] tagFlat,
  output stackStrobe_t               strobe,
  output logic [STK_PTR_W-1:0]       topQ,
  output logic [STK_PTR_W-1:0]       rdSlot,
  output logic                       ovfQ,
  output logic                       unfQ
);

  localparam logic [STK_PTR_W-1:0] PTR_ONE = 1;

  logic [STK_PTR_W-1:0] topNext;
  logic [STK_PTR_W-1:0] relSlot;
  logic [STK_PTR_W-1:0] belowTop;
  logic                 ovfNext;
  logic                 unfNext;

  function automatic logic slotEmpty(input logic [TAG_W*STK_DEPTH-1:0] flat,
                                     input logic [STK_PTR_W-1:0] s);
    return flat[TAG_W*s +: TAG_W] == TAG_EMPTY;
  endfunction

  // Pointer arithmetic wraps in STK_PTR_W bits (depth is a power of two)
  assign relSlot  = topQ + stIdx;
  assign belowTop = topQ - PTR_ONE;
  assign rdSlot   = relSlot;

  always_comb begin
    strobe  = '0;
    topNext = topQ;
    ovfNext = 1'b0;
    unfNext = 1'b0;
    case (opCode)
      OP_PUSH: begin
        strobe.load = 1'b1;
        strobe.slot = belowTop;
        ovfNext     = !slotEmpty(tagFlat, belowTop);
        topNext     = belowTop;
      end
      OP_POP: begin
        strobe.vacate = 1'b1;
        strobe.slot   = topQ;
        unfNext       = slotEmpty(tagFlat, topQ);
        topNext       = topQ + PTR_ONE;
      end
      OP_READ: begin
        unfNext = slotEmpty(tagFlat, relSlot);
      end
      OP_WRITE: begin
        strobe.load = 1'b1;
        strobe.slot = relSlot;
      end
      default: begin
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      topQ <= '0;
      ovfQ <= 1'b0;
      unfQ <= 1'b0;
    end else begin
      topQ <= topNext;
      ovfQ <= ovfNext;
      unfQ <= unfNext;
    end
  end

endmodule

// File: rtl/tstk_datapath.sv
module tstk_datapath
  import tstk_pkg::*;
#(
  parameter  int EXP_W = 15,
  parameter  int SIG_W = 64,
  localparam int WIDTH = 1 + EXP_W + SIG_W
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  stackStrobe_t               strobe,
  input  logic [STK_PTR_W-1:0]       rdSlot,
  input  logic [WIDTH-1:0]           wrData,
  output logic [WIDTH-1:0]           rdData,
  output logic [TAG_W-1:0]           rdTag,
  output logic [TAG_W*STK_DEPTH-1:0] tagFlat
);

  logic [WIDTH-1:0] dataQ [STK_DEPTH];
  tag_e             tagQ  [STK_DEPTH];
  tag_e             newTag;

  logic [EXP_W-1:0] wrExp;
  logic [SIG_W-1:0] wrSig;

  assign wrExp = wrData[SIG_W +: EXP_W];
  assign wrSig = wrData[SIG_W-1:0];

  // Class of the incoming value; sign bit is not consulted
  always_comb begin
    if (wrExp == '0 && wrSig == '0) newTag = TAG_ZERO;
    else if (&wrExp)                newTag = TAG_SPECIAL;
    else                            newTag = TAG_VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STK_DEPTH; k++) begin
        dataQ[k] <= '0;
        tagQ[k]  <= TAG_EMPTY;
      end
    end else if (strobe.load) begin
      dataQ[strobe.slot] <= wrData;
      tagQ[strobe.slot]  <= newTag;
    end else if (strobe.vacate) begin
      tagQ[strobe.slot]  <= TAG_EMPTY;
    end
  end

  assign rdData = dataQ[rdSlot];
  assign rdTag  = tagQ[rdSlot];

  generate
    for (genvar k = 0; k < STK_DEPTH; k++) begin : g_tagPack
      assign tagFlat[TAG_W*k +: TAG_W] = tagQ[k];
    end
  endgenerate

endmodule

// File: rtl/tagged_reg_stack.sv
module tagged_reg_stack
  import tstk_pkg::*;
#(
  parameter  int EXP_W = 15,
  parameter  int SIG_W = 64,
  localparam int WIDTH = 1 + EXP_W + SIG_W
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 opCode,
  input  logic [STK_PTR_W-1:0]       stIdx,
  input  logic [WIDTH-1:0]           wrData,
  output logic [WIDTH-1:0]           rdData,
  output logic [TAG_W-1:0]           rdTag,
  output logic [STK_PTR_W-1:0]       topPtr,
  output logic [TAG_W*STK_DEPTH-1:0] tagWord,
  output logic                       ovfFlag,
  output logic                       unfFlag,
  output logic                       invalidOp
);

  stackStrobe_t         strobe;
  logic [STK_PTR_W-1:0] rdSlot;

  tstk_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .opCode  (opCode),
    .stIdx   (stIdx),
    .tagFlat (tagWord),
    .strobe  (strobe),
    .topQ    (topPtr),
    .rdSlot  (rdSlot),
    .ovfQ    (ovfFlag),
    .unfQ    (unfFlag)
  );

  tstk_datapath #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .rdSlot  (rdSlot),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdTag   (rdTag),
    .tagFlat (tagWord)
  );

  assign invalidOp = ovfFlag | unfFlag;

endmodule

// File: rtl/tagged_reg_stack_chk.sv
module tagged_reg_stack_chk #(
  parameter int EXP_W = 15,
  parameter int SIG_W = 64
)(
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             opCode,
  input logic [2:0]             stIdx,
  input logic [EXP_W+SIG_W:0]   wrData,
  input logic [2:0]             topPtr,
  input logic [15:0]            tagWord,
  input logic                   ovfFlag,
  input logic                   unfFlag,
  input logic                   invalidOp
);

  function automatic logic [1:0] tagOf(input logic [15:0] w, input logic [2:0] k);
    return w[2*k +: 2];
  endfunction

  logic wrIsZero;
  assign wrIsZero = (wrData[EXP_W+SIG_W-1:0] == '0);

  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd1) |=> (topPtr == $past(topPtr) - 3'd1));

  assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd2) |=> (topPtr == $past(topPtr) + 3'd1));

  assert_pop_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd2) |=> (tagOf(tagWord, $past(topPtr)) == 2'b11));

  assert_zero_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode == 3'd1 && wrIsZero) |=> (tagOf(tagWord, topPtr) == 2'b01));

  assert_top_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode != 3'd1 && opCode != 3'd2) |=> $stable(topPtr));

  assert_ovf_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovfFlag |-> ($past(opCode) == 3'd1));

  assert_unf_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unfFlag |-> ($past(opCode) == 3'd2 || $past(opCode) == 3'd3));

  assert_inv_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    invalidOp |-> (ovfFlag || unfFlag));

endmodule

bind tagged_reg_stack tagged_reg_stack_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opCode    (opCode),
  .stIdx     (stIdx),
  .wrData    (wrData),
  .topPtr    (topPtr),
  .tagWord   (tagWord),
  .ovfFlag   (ovfFlag),
  .unfFlag   (unfFlag),
  .invalidOp (invalidOp)
);

// File: tb/tagged_reg_stack_bench.sv
`timescale 1ns/1ps
module tagged_reg_stack_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  opCode;
  logic [2:0]  stIdx;
  logic [79:0] wrData;
  logic [79:0] rdData;
  logic [1:0]  rdTag;
  logic [2:0]  topPtr;
  logic [15:0] tagWord;
  logic        ovfFlag, unfFlag, invalidOp;

  always #5 clk = ~clk;

  tagged_reg_stack u_tagged_reg_stack (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .stIdx(stIdx), .wrData(wrData),
    .rdData(rdData), .rdTag(rdTag), .topPtr(topPtr), .tagWord(tagWord),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag), .invalidOp(invalidOp)
  );

  // Behavioural reference model
  logic [79:0] mData [8];
  logic [1:0]  mTag  [8];
  int          mTop;
  logic        expOvf, expUnf;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  function automatic logic [1:0] classOf(input logic [79:0] v);
    if (v[78:64] == 15'h0 && v[63:0] == 64'h0) return 2'b01;
    if (v[78:64] == 15'h7FFF)                  return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(input string req, input logic [2:0] ix);
    logic [15:0] tw;
    int s;
    for (int k = 0; k < 8; k++) tw[2*k +: 2] = mTag[k];
    s = (mTop + ix) % 8;
    chk(req, "R2 R3 topPtr", {77'd0, topPtr}, mTop[79:0]);
    chk(req, "R5 tagWord", {64'd0, tagWord}, {64'd0, tw});
    chk(req, "R4 rdData", rdData, mData[s]);
    chk(req, "R4 rdTag", {78'd0, rdTag}, {78'd0, mTag[s]});
    chk(req, "R8 ovfFlag", {79'd0, ovfFlag}, {79'd0, expOvf});
    chk(req, "R9 unfFlag", {79'd0, unfFlag}, {79'd0, expUnf});
    chk(req, "R10 invalidOp", {79'd0, invalidOp}, {79'd0, expOvf | expUnf});
  endtask

  // Drive one operation, check outputs before its edge, then advance the model
  task automatic step(input logic [2:0] op, input logic [2:0] ix,
                      input logic [79:0] d, input string req);
    int s;
    @(negedge clk);
    opCode = op; stIdx = ix; wrData = d;
    #1;
    compareAll(req, ix);
    expOvf = 1'b0; expUnf = 1'b0;
    case (op)
      3'd1: begin
        s = (mTop + 7) % 8;
        expOvf = (mTag[s] != 2'b11);
        mData[s] = d; mTag[s] = classOf(d); mTop = s;
      end
      3'd2: begin
        expUnf = (mTag[mTop] == 2'b11);
        mTag[mTop] = 2'b11;
        mTop = (mTop + 1) % 8;
      end
      3'd3: expUnf = (mTag[(mTop + ix) % 8] == 2'b11);
      3'd4: begin
        s = (mTop + ix) % 8;
        mData[s] = d; mTag[s] = classOf(d);
      end
      default: ;
    endcase
  endtask

  function automatic logic [79:0] pickValue(input int kind);
    logic [79:0] v;
    v = {$urandom, $urandom, $urandom};
    case (kind)
      0: v[78:0] = '0;
      1: v[78:64] = 15'h7FFF;
      default: if (v[78:64] == 15'h7FFF) v[78:64] = 15'h1234;
    endcase
    return v;
  endfunction

  initial begin
    rst_n = 1'b0; opCode = 3'd0; stIdx = 3'd0; wrData = '0;
    for (int k = 0; k < 8; k++) begin mData[k] = '0; mTag[k] = 2'b11; end
    mTop = 0; expOvf = 1'b0; expUnf = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "topPtr", {77'd0, topPtr}, 80'd0);
    chk("R1", "tagWord", {64'd0, tagWord}, {64'd0, 16'hFFFF});
    chk("R1", "flags", {77'd0, ovfFlag, unfFlag, invalidOp}, 80'd0);
    rst_n = 1'b1;

    // R6: classification, sign ignored; R2: first push wraps top to 7
    step(3'd1, 3'd0, 80'h0, "R6 zero");
    step(3'd1, 3'd0, {1'b1, 79'h0}, "R6 negzero");
    step(3'd1, 3'd0, {1'b0, 15'h7FFF, 64'h0}, "R6 special");
    step(3'd1, 3'd0, {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000}, "R6 normal");
    step(3'd1, 3'd0, {1'b0, 15'h0, 64'h1}, "R6 denormal");
    step(3'd1, 3'd0, {1'b1, 15'h7FFF, 64'hC000_0000_0000_0000}, "R6 negspecial");
    step(3'd1, 3'd0, 80'h4000_1234_5678_9ABC_DEF0, "R2 push");
    step(3'd1, 3'd0, 80'h3FFE_AAAA_5555_AAAA_5555, "R2 push8");
    // R8: ninth push lands on occupied register
    step(3'd1, 3'd0, 80'h4001_1111_2222_3333_4444, "R8 overflow");
    // R4: read every ST(i)
    for (int i = 0; i < 8; i++) step(3'd3, i[2:0], 80'h0, "R4 read");
    // R7: write ST(3) and ST(6)
    step(3'd4, 3'd3, 80'h0, "R7 write zero");
    step(3'd4, 3'd6, 80'h7FFF_0000_0000_0000_0001, "R7 write special");
    // R11: unused opcodes are no-ops
    step(3'd5, 3'd2, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, "R11 op5");
    step(3'd6, 3'd1, 80'h0, "R11 op6");
    step(3'd7, 3'd0, 80'h0, "R11 op7");
    step(3'd0, 3'd4, 80'h0, "R11 nop");
    // R3: drain stack, then R9: pop and read of empty
    for (int i = 0; i < 8; i++) step(3'd2, 3'd0, 80'h0, "R3 pop");
    step(3'd2, 3'd0, 80'h0, "R9 pop empty");
    step(3'd3, 3'd2, 80'h0, "R9 read empty");
    step(3'd0, 3'd0, 80'h0, "R9 after");

    // Mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] op;
      op = $urandom_range(0, 7);
      if (op > 3'd4 && ($urandom_range(0, 3) != 0)) op = $urandom_range(1, 3);
      step(op, $urandom_range(0, 7), pickValue($urandom_range(0, 2)), "random");
    end
    step(3'd0, 3'd0, 80'h0, "final");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule